// File: doc/BRIEF.md
# Signed Integer ALU

This block executes the arithmetic, comparison, bitwise and shift operations of a small programmable controller on 32-bit signed integers. The controller presents an opcode and two operands and pulses `start`. The second operand is either a register value or an immediate that has already been expanded to 32 bits. Most operations finish in one cycle. Division and remainder go through an iterative restoring divider that handles one quotient bit per cycle.

Division rounds its quotient toward negative infinity. Remainder keeps the truncating convention, so its sign follows the dividend. A zero divisor produces no value: it raises `err` alongside `done`. Each result is held on `result` until the next completion. While a divide is in progress, any new `start` is ignored.

Top module: `sint_alu`

## Requirements
- R1: Add (code 0), subtract (code 1) and multiply (code 2) wrap modulo 2^32 with no overflow indication, and multiply returns the low 32 bits of the product.
- R2: AND (code 6), OR (code 7) and XOR (code 8) are bitwise over both operands. NOT (code 9) inverts every bit of `opa` and ignores `opb`.
- R3: Shifts use only bits [4:0] of `opb` as the amount. Left logical (code 10) and right logical (code 11) fill with zeros. Right arithmetic (code 12) replicates bit 31 of `opa`.
- R4: Set-less-than (code 5) returns 1 when `opa` is less than `opb` as signed numbers, and 0 otherwise.
- R5: Divide (code 3) with a nonzero divisor returns the quotient rounded toward negative infinity.
- R6: Remainder (code 4) with a nonzero divisor returns the truncated remainder. Its magnitude is |opa| mod |opb| and its sign is that of `opa`.
- R7: Divide or remainder by zero sets `done` and `err` in the cycle after `start`, and `result` becomes 0.
- R8: The most negative value divided by -1 returns 0x80000000 with `err` low, and its remainder is 0.
- R9: Every operation other than divide and remainder with a nonzero divisor raises `done` for exactly one cycle. If `start` is high in cycle n, that cycle is n+1, and `err` is low.
- R10: Divide and remainder with a nonzero divisor raise `done` in cycle n+34, where n is the cycle in which `start` was accepted. `err` is low in that cycle.
- R11: A `start` that arrives while a divide is in progress is ignored. No extra `done` appears, and the running divide completes on time with its own operands.
- R12: While `rst_n` is low at a clock edge, `result`, `done` and `err` are cleared to 0 and any divide in progress is abandoned.
- R13: Opcodes 13 to 15 are unused. They return `result` = 0 with single-cycle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation with the current op and operands |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand, also the dividend |
| opb | input | 32 | Second operand, register or expanded immediate |
| result | output | 32 | Result of the last completed operation |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero-divisor indication, valid with done |

## Verification
The assertions assume that `opa`, `opb` and `op` are sampled only in the cycle where `start` is accepted. They make no assumption about the operands while the divider runs, because the divider keeps its own copies. The stimulus changes the operands only at falling edges and drops `start` right after it has been sampled. It also deliberately raises `start` in the middle of a divide, with different operands, to show that the captured copies are the ones used.

// File: rtl/sint_alu_pkg.sv
// Package: shared width and operation codes for the signed ALU.
// Assumes a 4-bit opcode field; codes 13..15 are unused.
package sint_alu_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_DIV = 4'd3,
        OP_REM = 4'd4,
        OP_SLT = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_NOT = 4'd9,
        OP_SLL = 4'd10,
        OP_SRL = 4'd11,
        OP_SRA = 4'd12
    } alu_op_e;

    // True for the operations routed through the iterative divider.
    function automatic logic is_div_op(input logic [OP_W-1:0] code);
        return (code == OP_DIV) || (code == OP_REM);
    endfunction
endpackage

// File: rtl/sint_alu_comb.sv
// Module: single-cycle datapath for every operation except divide/remainder.
// Assumes operands are W bits two's complement; unknown codes give zero.
module sint_alu_comb
    import sint_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    localparam int unsigned SH_W = $clog2(W);

    logic [SH_W-1:0] shamt;
    assign shamt = b[SH_W-1:0];

    // Select the operation result.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            OP_SLL:  y = a << shamt;
            OP_SRL:  y = a >> shamt;
            OP_SRA:  y = W'($signed(a) >>> shamt);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/sint_alu_div.sv
// Module: restoring divider, one quotient bit per cycle, with signed fix-up.
// Quotient is floored; remainder carries the dividend's sign.
// Assumes launch is only raised when busy is low and the divisor is nonzero.
module sint_alu_div
    import sint_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rmd
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     acc_q;
    logic [W-1:0]     shf_q;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     dnd_q;
    logic             sa_q;
    logic             sb_q;
    logic [W:0]       trial;
    logic [W-1:0]     a_mag;
    logic [W-1:0]     b_mag;
    logic [W-1:0]     q_trunc;

    assign a_mag = dividend[W-1] ? -dividend : dividend;
    assign b_mag = divisor[W-1]  ? -divisor  : divisor;
    assign trial = {acc_q, shf_q[W-1]} - {1'b0, dvs_q};

    // Load operands on launch, then do one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            acc_q <= '0;
            shf_q <= '0;
            dvs_q <= '0;
            dnd_q <= '0;
            sa_q  <= 1'b0;
            sb_q  <= 1'b0;
        end else if (launch) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(W);
            acc_q <= '0;
            shf_q <= a_mag;
            dvs_q <= b_mag;
            dnd_q <= a_mag;
            sa_q  <= dividend[W-1];
            sb_q  <= divisor[W-1];
        end else if (run_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (!trial[W]) begin
                acc_q <= trial[W-1:0];
                shf_q <= {shf_q[W-2:0], 1'b1};
            end else begin
                acc_q <= {acc_q[W-2:0], shf_q[W-1]};
                shf_q <= {shf_q[W-2:0], 1'b0};
            end
        end else if (fin) begin
            run_q <= 1'b0;
        end
    end

    assign busy = run_q;
    assign fin  = run_q && (cnt_q == '0);

    // Signed fix-up: truncate, then step down once for an inexact negative quotient.
    always_comb begin
        q_trunc = (sa_q ^ sb_q) ? -shf_q : shf_q;
        quo     = q_trunc - {{(W-1){1'b0}}, ((sa_q ^ sb_q) && acc_q != '0)};
        rmd     = sa_q ? -acc_q : acc_q;
    end

    // R5: magnitudes satisfy quotient*divisor + remainder == dividend at completion.
    a_r5_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (({{W{1'b0}}, shf_q} * {{W{1'b0}}, dvs_q} + {{W{1'b0}}, acc_q})
                 == {{W{1'b0}}, dnd_q}));

    // R6: remainder magnitude stays below the divisor magnitude.
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (acc_q < dvs_q));

    // R10: the step counter never exceeds the word width while running.
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= CNT_W'(W)));
endmodule

// File: rtl/sint_alu.sv
// Module: signed integer ALU top. Accepts start when idle, returns result,
// a one-cycle done pulse, and err for a zero divisor.
// Assumes op and operands are valid in the cycle start is accepted.
module sint_alu
    import sint_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    output logic [W-1:0]    result,
    output logic            done,
    output logic            err
);
    logic         busy;
    logic         fin;
    logic         accept;
    logic         div_req;
    logic         zero_div;
    logic         launch;
    logic         want_rem_q;
    logic [W-1:0] comb_y;
    logic [W-1:0] quo;
    logic [W-1:0] rmd;

    assign accept   = start && !busy;
    assign div_req  = is_div_op(op);
    assign zero_div = div_req && (opb == '0);
    assign launch   = accept && div_req && !zero_div;

    sint_alu_comb #(.W(W)) u_comb (
        .op (op),
        .a  (opa),
        .b  (opb),
        .y  (comb_y)
    );

    sint_alu_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .dividend (opa),
        .divisor  (opb),
        .busy     (busy),
        .fin      (fin),
        .quo      (quo),
        .rmd      (rmd)
    );

    // Register results and the completion pulse for both paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
            want_rem_q <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (fin) begin
                result <= want_rem_q ? rmd : quo;
                done   <= 1'b1;
            end else if (launch) begin
                want_rem_q <= (op == OP_REM);
            end else if (accept) begin
                result <= zero_div ? '0 : comb_y;
                done   <= 1'b1;
                err    <= zero_div;
            end
        end
    end

    // R1: add result equals the wrapped sum of the sampled operands.
    a_r1_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_ADD) |=> (result == $past(opa + opb)));

    // R4: set-less-than yields only 0 or 1.
    a_r4_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_SLT) |=> (result[W-1:1] == '0 && done));

    // R7: zero divisor completes next cycle with err and a zero result.
    a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && zero_div) |=> (done && err && result == '0));

    // R9: err is never raised outside a completion pulse.
    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R11: no completion while the divider is still iterating.
    a_r11_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> !done);
endmodule

// File: tb/test_sint_alu.sv
// Bench: walks a vector table, then runs directed reset and corner tests.
module test_sint_alu;
    import sint_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        done;
    logic        err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sint_alu i_sint_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op     (op),
        .opa    (opa),
        .opb    (opb),
        .result (result),
        .done   (done),
        .err    (err)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] y;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  32'd5,        32'd7,        32'd12,       8'd1},  // R1
        '{4'd0,  32'h7FFFFFFF, 32'd1,        32'h80000000, 8'd1},  // R1 wrap
        '{4'd1,  32'd3,        32'd5,        32'hFFFFFFFE, 8'd1},  // R1
        '{4'd2,  32'h00010000, 32'h00010000, 32'h00000000, 8'd1},  // R1 low bits
        '{4'd2,  32'hFFFFFFFD, 32'd7,        32'hFFFFFFEB, 8'd1},  // R1 -3*7
        '{4'd6,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 8'd2},  // R2
        '{4'd7,  32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 8'd2},  // R2
        '{4'd8,  32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00F0F, 8'd2},  // R2
        '{4'd9,  32'h12345678, 32'hFFFFFFFF, 32'hEDCBA987, 8'd2},  // R2 opb ignored
        '{4'd9,  32'h12345678, 32'h00000000, 32'hEDCBA987, 8'd2},  // R2 opb ignored
        '{4'd10, 32'd1,        32'h00000021, 32'd2,        8'd3},  // R3 low 5 bits
        '{4'd10, 32'h80000001, 32'd4,        32'h00000010, 8'd3},  // R3
        '{4'd11, 32'h80000000, 32'd31,       32'd1,        8'd3},  // R3 zero fill
        '{4'd12, 32'h80000000, 32'd4,        32'hF8000000, 8'd3},  // R3 sign fill
        '{4'd12, 32'h70000000, 32'h00000024, 32'h07000000, 8'd3},  // R3
        '{4'd5,  32'hFFFFFFFF, 32'd1,        32'd1,        8'd4},  // R4 signed
        '{4'd5,  32'd1,        32'hFFFFFFFF, 32'd0,        8'd4},  // R4
        '{4'd5,  32'd5,        32'd5,        32'd0,        8'd4},  // R4 equal
        '{4'd3,  32'd7,        32'd2,        32'd3,        8'd5},  // R5
        '{4'd3,  32'hFFFFFFF9, 32'd2,        32'hFFFFFFFC, 8'd5},  // R5 -7/2=-4
        '{4'd3,  32'd7,        32'hFFFFFFFE, 32'hFFFFFFFC, 8'd5},  // R5 7/-2=-4
        '{4'd3,  32'hFFFFFFF9, 32'hFFFFFFFE, 32'd3,        8'd5},  // R5
        '{4'd3,  32'hFFFFFFFA, 32'd3,        32'hFFFFFFFE, 8'd5},  // R5 exact
        '{4'd3,  32'd100,      32'd7,        32'd14,       8'd5},  // R5
        '{4'd4,  32'd7,        32'd2,        32'd1,        8'd6},  // R6
        '{4'd4,  32'hFFFFFFF9, 32'd2,        32'hFFFFFFFF, 8'd6},  // R6
        '{4'd4,  32'd7,        32'hFFFFFFFE, 32'd1,        8'd6},  // R6
        '{4'd4,  32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 8'd6},  // R6
        '{4'd3,  32'h80000000, 32'hFFFFFFFF, 32'h80000000, 8'd8},  // R8
        '{4'd4,  32'h80000000, 32'hFFFFFFFF, 32'd0,        8'd8},  // R8
        '{4'd15, 32'd9,        32'd9,        32'd0,        8'd13}  // R13
    };

    // Record one check; print a FAIL line with actual and expected values.
    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one operation from a falling edge and wait for done.
    task automatic issue(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         output logic [31:0] res, output logic er, output int lat);
        op = o; opa = x; opb = y; start = 1'b1; lat = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                lat = i;
                break;
            end
        end
        res = result;
        er  = err;
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] res;
        logic        er;
        int          lat;
        int          exp_lat;
        bit          early;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk(result == 0, "R12 reset result", result, 0);
        chk(done == 0 && err == 0, "R12 reset flags", {30'd0, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            issue(VECS[k].op, VECS[k].a, VECS[k].b, res, er, lat);
            exp_lat = is_div_op(VECS[k].op) ? 34 : 1;
            chk(res == VECS[k].y, $sformatf("R%0d result vec %0d", VECS[k].req, k), res, VECS[k].y);
            chk(lat == exp_lat, $sformatf("R%0d latency vec %0d (R9/R10)", VECS[k].req, k),
                lat, exp_lat);
            chk(er == 0, $sformatf("R%0d err vec %0d", VECS[k].req, k), {31'd0, er}, 0);
        end

        // R9: done is a single-cycle pulse
        issue(4'd0, 32'd1, 32'd1, res, er, lat);
        @(negedge clk);
        chk(done == 0, "R9 done pulse width", {31'd0, done}, 0);

        // R7: division and remainder by zero
        issue(4'd3, 32'd5, 32'd0, res, er, lat);
        chk(res == 0 && er == 1 && lat == 1, "R7 div by zero",
            {res[15:0], 7'd0, er, lat[7:0]}, {16'd0, 7'd0, 1'b1, 8'd1});
        issue(4'd4, 32'd0, 32'd0, res, er, lat);
        chk(res == 0 && er == 1 && lat == 1, "R7 rem by zero",
            {res[15:0], 7'd0, er, lat[7:0]}, {16'd0, 7'd0, 1'b1, 8'd1});

        // R11: start during a divide is ignored
        op = 4'd3; opa = 32'd100; opb = 32'd7; start = 1'b1;
        lat = 0; early = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (i == 5) begin
                op = 4'd0; opa = 32'd1; opb = 32'd1; start = 1'b1;
            end
            if (done) begin
                lat = i;
                break;
            end
        end
        start = 1'b0;
        chk(lat == 34, "R11 divide latency unchanged", lat, 34);
        chk(result == 32'd14, "R11 divide keeps own operands", result, 14);
        @(negedge clk);
        chk(done == 0, "R11 no extra done", {31'd0, done}, 0);

        // R12: reset in the middle of a divide
        op = 4'd3; opa = 32'd50; opb = 32'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result == 0 && done == 0 && err == 0, "R12 mid-run reset", result, 0);
        rst_n = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (done) chk(0, "R12 abandoned divide completed", {31'd0, done}, 0);
        end
        issue(4'd0, 32'd2, 32'd3, res, er, lat);
        chk(res == 5 && lat == 1, "R12 operation after reset", res, 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule